// File: doc/BRIEF.md
# Inter-core interrupt signalling unit

This block lets the cores of a small cluster interrupt one another. A core presents a command with a valid strobe. The command carries an operation code, a target-core field and the identity of the issuing core. Each command completes in a single cycle. The unit drives one interrupt line per core. For every receiving core it keeps a vector with one bit per sending core, and the receiver's line is high while any bit in that vector is set.

When several senders signal the same receiver before it responds, their requests merge onto one asserted line. The receiver then asks which cores signalled it and gets back a vector with several bits set. It acknowledges each sender on its own, and the line drops only when the last sender bit is cleared. Any core can also ask whether a given core currently has an interrupt pending. The answers to both queries appear on a registered readback output.

Top module: `ipi_unit`

## Requirements
- R1: After reset every interrupt line is low and the readback output is zero.
- R2: A raise command (code 1) from issuer s to target t, where s differs from t, sets sender bit s for receiver t. The line for t is high from the cycle after the command.
- R3: A raise command whose target equals its issuer leaves every interrupt line and every pending vector unchanged.
- R4: Raise commands from several senders to one target merge onto that target's single line. Raising an already pending sender/target pair changes nothing.
- R5: A status command (code 2) loads the readback with 1 in bit 0 if the target's line is high and 0 otherwise. All other bits are zero.
- R6: A source command (code 3) loads the readback with the issuer's own pending vector, where bit k set means core k signalled it, for example 2 for core 1 alone and 14 for cores 1, 2 and 3.
- R7: An acknowledge command (code 4) clears only bit `target` of the issuer's pending vector. The other pending senders and the line stay as they were.
- R8: A receiver's line falls on the cycle after the acknowledge that clears its last pending sender bit.
- R9: The readback holds its value through every cycle that carries no status or source command.
- R10: A cycle with the valid strobe low, or with an undefined code (0, 5, 6, 7), changes no line and no readback value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Operation: 1 raise, 2 status, 3 source, 4 acknowledge |
| cmd_target | input | IDX_W | Target core, or the sender index for acknowledge |
| cmd_issuer | input | IDX_W | Identity of the core issuing the command |
| irq_o | output | N_CORES | One interrupt line per core |
| rdback_o | output | N_CORES | Registered result of the last status or source command |

## Verification
The bound checker watches every cycle for several rules. A valid raise lights the target's line, and a self-raise never lights the issuer's line. A line only rises after a raise aimed at it. Idle cycles leave the lines frozen, and the readback moves only on status or source commands and then agrees with the line it reports on. Other behaviour needs a reference model of the pending vectors, so only the bench's scenarios can show it. This covers the exact sender vector returned by a source command, the merging of requests from several senders, acknowledges that clear one bit and leave the others, and the drop of the line on the last acknowledge. The bench sweeps every sender/target pair of a four-core cluster for these.

// File: rtl/ipi_unit.sv
module ipi_unit #(
  parameter int N_CORES = 4,
  parameter int CODE_W  = 3,
  localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [CODE_W-1:0]  cmd_code,
  input  logic [IDX_W-1:0]   cmd_target,
  input  logic [IDX_W-1:0]   cmd_issuer,
  output logic [N_CORES-1:0] irq_o,
  output logic [N_CORES-1:0] rdback_o
);
  localparam logic [CODE_W-1:0] OP_RAISE  = CODE_W'(1);
  localparam logic [CODE_W-1:0] OP_STATUS = CODE_W'(2);
  localparam logic [CODE_W-1:0] OP_SOURCE = CODE_W'(3);
  localparam logic [CODE_W-1:0] OP_ACK    = CODE_W'(4);

  logic [N_CORES-1:0] pend [N_CORES];

  wire tgt_ok = 32'(cmd_target) < N_CORES;
  wire iss_ok = 32'(cmd_issuer) < N_CORES;
  wire do_raise = cmd_valid && cmd_code == OP_RAISE && tgt_ok && iss_ok && cmd_target != cmd_issuer;
  wire do_ack   = cmd_valid && cmd_code == OP_ACK && tgt_ok && iss_ok;

  for (genvar i = 0; i < N_CORES; i++) begin : g_rx
    always_ff @(posedge clk) begin
      if (!rst_n)
        pend[i] <= '0;
      else if (do_raise && 32'(cmd_target) == i)
        pend[i][cmd_issuer] <= 1'b1;
      else if (do_ack && 32'(cmd_issuer) == i)
        pend[i][cmd_target] <= 1'b0;
    end
    assign irq_o[i] = |pend[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdback_o <= '0;
    else if (cmd_valid && cmd_code == OP_STATUS)
      rdback_o <= tgt_ok ? N_CORES'(irq_o[cmd_target]) : '0;
    else if (cmd_valid && cmd_code == OP_SOURCE)
      rdback_o <= iss_ok ? pend[cmd_issuer] : '0;
  end
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk #(
  parameter int N_CORES = 4,
  parameter int CODE_W  = 3,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [CODE_W-1:0]  cmd_code,
  input logic [IDX_W-1:0]   cmd_target,
  input logic [IDX_W-1:0]   cmd_issuer,
  input logic [N_CORES-1:0] irq_o,
  input logic [N_CORES-1:0] rdback_o
);
  wire raise_c = cmd_valid && cmd_code == CODE_W'(1);
  wire stat_c  = cmd_valid && cmd_code == CODE_W'(2);
  wire src_c   = cmd_valid && cmd_code == CODE_W'(3);

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (irq_o == '0 && rdback_o == '0));

  p_idle_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(irq_o));

  p_rdback_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_c || src_c) |=> $stable(rdback_o));

  for (genvar i = 0; i < N_CORES; i++) begin : g_c
    p_raise_lights_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_c && 32'(cmd_target) == i && cmd_issuer != cmd_target) |=> irq_o[i]);

    p_self_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_c && 32'(cmd_target) == i && 32'(cmd_issuer) == i && !irq_o[i]) |=> !irq_o[i]);

    p_rise_needs_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o[i] && !(raise_c && 32'(cmd_target) == i)) |=> !irq_o[i]);

    p_status_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_c && 32'(cmd_target) == i) |=> rdback_o == N_CORES'($past(irq_o[i])));

    p_source_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_c && 32'(cmd_issuer) == i) |=> (($countones(rdback_o) != 0) == $past(irq_o[i])));
  end
endmodule

bind ipi_unit ipi_unit_chk #(.N_CORES(N_CORES), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/ipi_unit_tb.sv
module ipi_unit_tb;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_code = 0;
  logic [1:0] cmd_target = 0, cmd_issuer = 0;
  logic [N-1:0] irq_o, rdback_o;
  logic [N-1:0] mp [N];
  logic [N-1:0] mrb;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ipi_unit u_dut (.clk, .rst_n, .cmd_valid, .cmd_code, .cmd_target, .cmd_issuer, .irq_o, .rdback_o);

  function automatic logic [N-1:0] m_irq();
    for (int i = 0; i < N; i++) m_irq[i] = |mp[i];
  endfunction

  task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic op(logic v, int code, int tgt, int iss, string req);
    @(negedge clk);
    cmd_valid = v; cmd_code = 3'(code); cmd_target = 2'(tgt); cmd_issuer = 2'(iss);
    if (v) begin
      case (code)
        1: if (tgt != iss) mp[tgt][iss] = 1'b1;
        2: mrb = N'(|mp[tgt]);
        3: mrb = mp[iss];
        4: mp[iss][tgt] = 1'b0;
        default: ;
      endcase
    end
    @(negedge clk);
    cmd_valid = 0;
    check({req, " irq"}, irq_o, m_irq());
    check({req, " rdback"}, rdback_o, mrb);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mp[i] = '0;
    mrb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq", irq_o, '0);
    check("R1 rdback", rdback_o, '0);

    for (int s = 0; s < N; s++)
      for (int t = 0; t < N; t++) begin
        if (s == t) begin
          op(1, 1, t, s, "R3");
          op(1, 3, 0, s, "R3 source");
        end else begin
          op(1, 1, t, s, "R2");
          op(1, 2, t, (t + 1) % N, "R5 pending");
          op(1, 3, 0, t, "R6");
          op(1, 1, t, s, "R4 repeat");
          op(0, 1, (t + 1) % N, t, "R10 idle");
          op(1, 4, s, t, "R8");
          op(1, 2, t, s, "R5 clear");
        end
      end

    for (int s = 1; s < N; s++) op(1, 1, 0, s, "R4 merge");
    op(1, 3, 0, 0, "R6 multi");
    check("R6 vector", rdback_o, 4'd14);
    op(1, 1, 2, 1, "R9 raise");
    op(1, 5, 1, 0, "R10 code5");
    op(1, 7, 1, 3, "R10 code7");
    op(1, 0, 1, 3, "R10 code0");
    op(1, 4, 2, 0, "R7 one");
    op(1, 3, 0, 0, "R7 rest");
    check("R7 vector", rdback_o, 4'd10);
    op(1, 4, 1, 2, "R9 ack");
    op(1, 4, 1, 0, "R7 two");
    op(1, 2, 0, 1, "R5 still");
    op(1, 4, 3, 0, "R8 last");
    op(1, 3, 0, 0, "R8 empty");
    check("R8 line", irq_o, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule